// File: doc/BRIEF.md
# Strobe-Strapped Setting Decoder

This block recovers a counter's operating settings from three active-low straps that the board ties to the display digit strobes. A scan visits eight digit slots in turn. For each slot the block receives the current digit index and a flag that marks the second half of the slot. The block records which digits pull each strap low, and only during that second half. When a scan ends, it turns those records into a measurement function, a gate range and a set of independent control flags.

The function strap and the range strap are each wired to a single digit. A new function or range takes effect only when two consecutive complete scans give the same result. A scan that finds no usable digit gives the defaults. The control strap may be wired to several digits at once, so each control flag has its own decode and follows every complete scan. A change of function raises a one-cycle restart pulse. A change of range raises the same pulse, except when the function is the free-running event count. When the display is blanked, all straps are ignored and every setting keeps its value until the blanking ends.

Top module: `strobe_cfg_decoder`

## Requirements
- R1: `func_o` codes the function from the digit (1-based) that pulls `fn_n_i` low: digit 1 gives 0 (frequency), digit 8 gives 1 (period), digit 2 gives 2 (ratio), digit 5 gives 3 (time interval), digit 4 gives 4 (event count) and digit 3 gives 5 (timebase self-test).
- R2: `range_o` is the digit on `rng_n_i` minus one. Digits 1 to 4 give 0 (10 ms / 1 cycle), 1, 2 and 3 (10 s / 1000 cycles).
- R3: Each control flag decodes from `ctl_n_i` on its own digit, and any combination may be active: digit 1 sets `ext_tb_o`, digit 2 sets `slow_xtal_o`, digit 3 sets `ext_dp_o`, digit 8 sets `disp_test_o`. The flags take effect at the end of the scan that holds them.
- R4: A strap is sampled only while `late_half_i` is high. A low level in the first half of a slot has no effect.
- R5: A new function or range value is adopted only after two consecutive complete scans yield it. One differing scan changes nothing.
- R6: A scan in which no mapped digit reaches the function strap yields frequency (0). A scan with no digit 1 to 4 on the range strap yields range 0. Digits 6 and 7 on the function strap count as no digit.
- R7: Each adopted function change raises `restart_o` for exactly one clock cycle.
- R8: An adopted range change raises `restart_o` for one cycle unless the resulting function is event count (4). In that case the range still updates and no pulse is raised.
- R9: `disp_off_o` is high when the last scan saw digit 4 on `ctl_n_i` and `hold_i` is high. While it is high, all straps are ignored and all outputs other than `disp_off_o` keep their values.
- R10: After reset, function is 0, range is 0, all flags are low and `restart_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_idx_i | input | 3 | Current scan digit, 0-based (0 = digit 1) |
| late_half_i | input | 1 | High during the second half of the digit slot |
| fn_n_i | input | 1 | Function strap, active low |
| rng_n_i | input | 1 | Range strap, active low |
| ctl_n_i | input | 1 | Control strap, active low, multi-digit |
| hold_i | input | 1 | Hold level; qualifies display blanking |
| func_o | output | 3 | Adopted function code |
| range_o | output | 2 | Adopted range code |
| disp_off_o | output | 1 | Display blanked |
| disp_test_o | output | 1 | Display test |
| slow_xtal_o | output | 1 | Low-frequency timebase select |
| ext_tb_o | output | 1 | External timebase enable |
| ext_dp_o | output | 1 | External decimal point enable |
| restart_o | output | 1 | One-cycle measurement restart |

## Verification
The hardest state to reach is the frozen one, because display blanking is set by the same control strap that it then ignores. The stimulus first runs a scan with digit 4 on the control strap while hold is high. It then runs full scans that carry a different function, a different range and other control digits, and confirms that nothing moves and no restart occurs. Last, it drops hold and confirms that two clean scans are needed before the function changes. Every slot pulls all three straps low in its first half, so every check also exercises the rule that only the second half is sampled.

// File: rtl/strobe_cfg_pkg.sv
package strobe_cfg_pkg;

  typedef enum logic [2:0] {
    FN_FREQ   = 3'd0,
    FN_PERIOD = 3'd1,
    FN_RATIO  = 3'd2,
    FN_TINT   = 3'd3,
    FN_COUNT  = 3'd4,
    FN_SELF   = 3'd5
  } func_e;

  // 0-based digit positions on the function strap
  localparam int unsigned DG_FREQ   = 0;
  localparam int unsigned DG_RATIO  = 1;
  localparam int unsigned DG_SELF   = 2;
  localparam int unsigned DG_COUNT  = 3;
  localparam int unsigned DG_TINT   = 4;
  localparam int unsigned DG_PERIOD = 7;

  localparam int unsigned RNG_CNT = 4;
  localparam int unsigned RNG_W   = $clog2(RNG_CNT);

  // 0-based digit positions on the control strap
  localparam int unsigned CG_EXT_TB = 0;
  localparam int unsigned CG_SLOW   = 1;
  localparam int unsigned CG_EXT_DP = 2;
  localparam int unsigned CG_OFF    = 3;
  localparam int unsigned CG_TEST   = 7;

  typedef struct packed {
    logic test;
    logic off;
    logic ext_dp;
    logic slow;
    logic ext_tb;
  } ctl_t;

endpackage

// File: rtl/strobe_scan_timer.sv
module strobe_scan_timer #(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIG_W-1:0] digit_idx_i,
  input  logic             late_i,
  input  logic             frozen_i,
  output logic             acc_en_o,
  output logic             commit_o
);
  localparam logic [DIG_W-1:0] LAST_DIG = DIG_W'(NUM_DIGITS - 1);

  logic             late_q;
  logic [DIG_W-1:0] dig_q;
  logic             armed_q;
  logic             first_dig;

  assign first_dig = (digit_idx_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      late_q  <= 1'b0;
      dig_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      late_q <= late_i;
      if (late_i) dig_q <= digit_idx_i;
      // a scan counts only if it was watched from its first digit
      if (frozen_i)                armed_q <= 1'b0;
      else if (late_i && first_dig) armed_q <= 1'b1;
    end
  end

  assign acc_en_o = late_i & ~frozen_i & (armed_q | first_dig);
  assign commit_o = late_q & ~late_i & (dig_q == LAST_DIG) & armed_q & ~frozen_i;

  p_commit_after_late_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ($past(late_i) && !late_i));

endmodule

// File: rtl/strobe_hit_accum.sv
module strobe_hit_accum #(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIG_W-1:0]      digit_idx_i,
  input  logic                  pin_n_i,
  input  logic                  acc_en_i,
  input  logic                  clear_i,
  output logic [NUM_DIGITS-1:0] hits_o
);
  logic [NUM_DIGITS-1:0] hits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q <= '0;
    end else if (clear_i) begin
      hits_q <= '0;
    end else if (acc_en_i && !pin_n_i) begin
      hits_q[digit_idx_i] <= 1'b1;
    end
  end

  assign hits_o = hits_q;

  p_hits_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !clear_i) |=> $stable(hits_q));

endmodule

// File: rtl/strobe_setting_filter.sv
module strobe_setting_filter
  import strobe_cfg_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_DIGITS-1:0] fn_hits_i,
  input  logic [NUM_DIGITS-1:0] rng_hits_i,
  input  logic                  commit_i,
  output func_e                 func_o,
  output logic [RNG_W-1:0]      range_o,
  output logic                  restart_o
);
  func_e            fn_new, fn_cand_q, func_q, func_nxt;
  logic [RNG_W-1:0] rng_new, rng_cand_q, range_q;
  logic             restart_q;
  logic             fn_take, rng_take;

  // lowest mapped digit wins; unmapped digits read as absent
  always_comb begin
    fn_new = FN_FREQ;
    for (int d = NUM_DIGITS - 1; d >= 0; d--) begin
      if (fn_hits_i[d]) begin
        case (d)
          DG_FREQ:   fn_new = FN_FREQ;
          DG_RATIO:  fn_new = FN_RATIO;
          DG_SELF:   fn_new = FN_SELF;
          DG_COUNT:  fn_new = FN_COUNT;
          DG_TINT:   fn_new = FN_TINT;
          DG_PERIOD: fn_new = FN_PERIOD;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rng_new = '0;
    for (int d = RNG_CNT - 1; d >= 0; d--) begin
      if (rng_hits_i[d]) rng_new = RNG_W'(d);
    end
  end

  assign fn_take  = (fn_new == fn_cand_q) && (fn_new != func_q);
  assign rng_take = (rng_new == rng_cand_q) && (rng_new != range_q);
  assign func_nxt = fn_take ? fn_new : func_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_cand_q  <= FN_FREQ;
      rng_cand_q <= '0;
      func_q     <= FN_FREQ;
      range_q    <= '0;
      restart_q  <= 1'b0;
    end else if (commit_i) begin
      fn_cand_q  <= fn_new;
      rng_cand_q <= rng_new;
      func_q     <= func_nxt;
      if (rng_take) range_q <= rng_new;
      restart_q  <= fn_take | (rng_take & (func_nxt != FN_COUNT));
    end else begin
      restart_q  <= 1'b0;
    end
  end

  assign func_o    = func_q;
  assign range_o   = range_q;
  assign restart_o = restart_q;

  p_restart_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |=> !restart_q);
  p_settle_on_scan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(func_q) && $stable(range_q)));
  p_restart_from_scan_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |-> $past(commit_i));
  p_func_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_q <= FN_SELF);

endmodule

// File: rtl/strobe_cfg_decoder.sv
module strobe_cfg_decoder
  import strobe_cfg_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIG_W-1:0] digit_idx_i,
  input  logic             late_half_i,
  input  logic             fn_n_i,
  input  logic             rng_n_i,
  input  logic             ctl_n_i,
  input  logic             hold_i,
  output logic [2:0]       func_o,
  output logic [1:0]       range_o,
  output logic             disp_off_o,
  output logic             disp_test_o,
  output logic             slow_xtal_o,
  output logic             ext_tb_o,
  output logic             ext_dp_o,
  output logic             restart_o
);
  localparam int unsigned NUM_PINS = 3;

  logic [NUM_PINS-1:0]   pin_n;
  logic [NUM_DIGITS-1:0] hits [NUM_PINS];
  logic                  acc_en, commit, frozen;
  ctl_t                  ctl_q;
  func_e                 func;
  logic                  unused_ctl_hits;

  assign pin_n  = {ctl_n_i, rng_n_i, fn_n_i};
  assign frozen = ctl_q.off & hold_i;

  strobe_scan_timer #(.NUM_DIGITS(NUM_DIGITS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .digit_idx_i (digit_idx_i),
    .late_i      (late_half_i),
    .frozen_i    (frozen),
    .acc_en_o    (acc_en),
    .commit_o    (commit)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    strobe_hit_accum #(.NUM_DIGITS(NUM_DIGITS)) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .digit_idx_i (digit_idx_i),
      .pin_n_i     (pin_n[g]),
      .acc_en_i    (acc_en),
      .clear_i     (commit | frozen),
      .hits_o      (hits[g])
    );
  end

  strobe_setting_filter #(.NUM_DIGITS(NUM_DIGITS)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fn_hits_i  (hits[0]),
    .rng_hits_i (hits[1]),
    .commit_i   (commit),
    .func_o     (func),
    .range_o    (range_o),
    .restart_o  (restart_o)
  );

  // control flags are independent and follow every complete scan
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (commit) begin
      ctl_q.ext_tb <= hits[2][CG_EXT_TB];
      ctl_q.slow   <= hits[2][CG_SLOW];
      ctl_q.ext_dp <= hits[2][CG_EXT_DP];
      ctl_q.off    <= hits[2][CG_OFF];
      ctl_q.test   <= hits[2][CG_TEST];
    end
  end

  assign unused_ctl_hits = ^hits[2];

  assign func_o      = func;
  assign disp_off_o  = frozen;
  assign disp_test_o = ctl_q.test;
  assign slow_xtal_o = ctl_q.slow;
  assign ext_tb_o    = ctl_q.ext_tb;
  assign ext_dp_o    = ctl_q.ext_dp;

  p_frozen_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> ($stable(ctl_q) && $stable(func_o) && $stable(range_o)));
  p_frozen_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> !restart_o);

endmodule

// File: tb/strobe_cfg_decoder_tb.sv
module strobe_cfg_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] digit_idx = '0;
  logic       late = 1'b0;
  logic       fn_n = 1'b1, rng_n = 1'b1, ctl_n = 1'b1, hold = 1'b0;
  logic [2:0] func;
  logic [1:0] range_v;
  logic       disp_off, disp_test, slow_xtal, ext_tb, ext_dp, restart;

  int checks = 0, failures = 0, restarts = 0, cycles = 0;

  always #2 clk = ~clk;

  strobe_cfg_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .digit_idx_i(digit_idx), .late_half_i(late),
    .fn_n_i(fn_n), .rng_n_i(rng_n), .ctl_n_i(ctl_n), .hold_i(hold),
    .func_o(func), .range_o(range_v), .disp_off_o(disp_off),
    .disp_test_o(disp_test), .slow_xtal_o(slow_xtal), .ext_tb_o(ext_tb),
    .ext_dp_o(ext_dp), .restart_o(restart)
  );

  always @(negedge clk) if (rst_n && restart) restarts++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // function code from 1-based digit, 0 = none
  function automatic int fmap(int d);
    case (d)
      1: return 0; 8: return 1; 2: return 2; 5: return 3; 4: return 4; 3: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int rmap(int d);
    return (d >= 1 && d <= 4) ? d - 1 : 0;
  endfunction

  // one full scan; all straps pulled low in every first half (R4 noise)
  task automatic scan(int fd, int rd, logic [7:0] mask);
    for (int d = 0; d < 8; d++) begin
      @(negedge clk);
      digit_idx = 3'(d); late = 1'b0; fn_n = 1'b0; rng_n = 1'b0; ctl_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      late = 1'b1;
      fn_n = !(fd == d + 1); rng_n = !(rd == d + 1); ctl_n = !mask[d];
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    digit_idx = '0; late = 1'b0; fn_n = 1'b1; rng_n = 1'b1; ctl_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int prev, r0, ef, er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 func", func, 0);
    chk("R10 range", range_v, 0);
    chk("R10 flags", {disp_off, disp_test, slow_xtal, ext_tb, ext_dp}, 0);
    chk("R10 restart", restart, 0);

    // R1/R6/R5/R7 function sweep
    prev = 0;
    for (int fd = 1; fd <= 9; fd++) begin
      int dd = (fd == 9) ? 0 : fd;
      r0 = restarts;
      scan(dd, 0, 8'h00); idle();
      chk("R5 one scan keeps func", func, prev);
      chk("R5 no restart after one scan", restarts - r0, 0);
      scan(dd, 0, 8'h00); idle();
      ef = fmap(dd);
      chk((dd == 0 || dd == 6 || dd == 7) ? "R6 default func" : "R1 func decode", func, ef);
      chk("R7 restart count", restarts - r0, (ef != prev) ? 1 : 0);
      prev = ef;
    end

    // R2/R8 range sweep in frequency then in event count
    for (int pass = 0; pass < 2; pass++) begin
      int fdig = (pass == 0) ? 1 : 4;
      scan(fdig, 0, 8'h00); scan(fdig, 0, 8'h00); idle();
      chk("R1 func for range pass", func, fmap(fdig));
      prev = range_v;
      for (int rd = 1; rd <= 5; rd++) begin
        int dd = (rd == 5) ? 0 : rd;
        r0 = restarts;
        scan(fdig, dd, 8'h00); scan(fdig, dd, 8'h00); idle();
        er = rmap(dd);
        chk((dd == 0) ? "R6 default range" : "R2 range decode", range_v, er);
        chk("R8 range restart", restarts - r0, (er != prev && pass == 0) ? 1 : 0);
        prev = er;
      end
    end

    // R5 single-scan glitch rejected
    r0 = restarts; prev = func;
    scan(8, 3, 8'h00); scan(4, 0, 8'h00); idle();
    chk("R5 glitch func", func, prev);
    chk("R5 glitch range", range_v, 0);
    chk("R5 glitch restart", restarts - r0, 0);

    // R3 every control mask, hold low so blanking never engages
    for (int m = 0; m < 256; m++) begin
      scan(4, 0, 8'(m)); idle();
      chk("R3 ext_tb", ext_tb, (m >> 0) & 1);
      chk("R3 slow_xtal", slow_xtal, (m >> 1) & 1);
      chk("R3 ext_dp", ext_dp, (m >> 2) & 1);
      chk("R3 disp_test", disp_test, (m >> 7) & 1);
      chk("R9 off needs hold", disp_off, 0);
    end
    chk("R4 first-half lows ignored", {disp_test, slow_xtal, ext_tb, ext_dp}, 4'b1111);
    scan(4, 0, 8'h00); idle();
    chk("R4 first-half lows ignored, clean", {disp_test, slow_xtal, ext_tb, ext_dp}, 0);

    // R9 blanking freezes everything
    hold = 1'b1;
    scan(4, 0, 8'h08); idle();
    chk("R9 blank on", disp_off, 1);
    r0 = restarts;
    scan(8, 3, 8'h81); scan(8, 3, 8'h81); idle();
    chk("R9 func frozen", func, 4);
    chk("R9 range frozen", range_v, 0);
    chk("R9 flags frozen", {disp_test, ext_tb}, 0);
    chk("R9 still blank", disp_off, 1);
    chk("R9 no restart", restarts - r0, 0);
    @(negedge clk); hold = 1'b0; #1;
    chk("R9 blank follows hold", disp_off, 0);
    scan(8, 0, 8'h00); idle();
    chk("R9/R5 one scan after release", func, 4);
    scan(8, 0, 8'h00); idle();
    chk("R9 func after release", func, 1);
    chk("R7 restart after release", restarts - r0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule